// File: doc/BRIEF.md
# Chained Variable-Length Serial Transmitter

This block is the transmit half of a clocked serial master. It can send bit strings longer than one word. A long string is split into a run of 16-bit segments, each marked with a chain flag, and ends with one unmarked segment whose length comes from a configuration field. The segments leave the data pin back to back, with no gap between them. The block inserts an optional parity bit and a configurable idle gap only after the unmarked segment. Each segment can be shifted out most significant bit first or least significant bit first.

Transmit words arrive over a valid/ready stream into a single holding slot.
- `s_ready` is high exactly when the slot is empty.
- A word transfers on a cycle where `s_valid` and `s_ready` are both high.
- A producer that sees `s_valid` high and `s_ready` low must hold `s_data` stable.
- The shifter empties the slot when it begins the word.

While one word shifts, the next can wait in the slot, so a chain runs without stalls when the producer keeps up. When the producer falls behind inside a chain, the serial clock pauses at its idle level and an underrun pulse is raised. The frame then resumes where it stopped.

Top module: `chain_ser_tx`

## Requirements
- R1: Once a word is accepted, `s_ready` is low on the next cycle and stays low until the shifter takes the word. Nothing is lost or overwritten while the slot is full.
- R2: A word with bit 29 set is a chained segment. It is always sent as 16 bits taken from bits 15:0, whatever `cfg_len` holds.
- R3: A word with bit 29 clear is a final segment of `cfg_len` bits, where a value of 0 means 16 bits. Only the lowest N payload bits of an N-bit segment are used. Bits 31:30 and 28:16 are ignored.
- R4: Inside a chain, the first bit of the next segment rises exactly one bit period (2 clocks) after the last bit of the previous segment, provided the next word is already held.
- R5: With `cfg_lsb_first`=0, bit N-1 of each segment goes out first and bit 0 goes out last. With `cfg_lsb_first`=1, bit 0 goes out first.
- R6: When `cfg_par_en`=1, exactly one parity bit follows the last bit of the final segment, and none follows a chained segment. The parity bit is the XOR of every data bit of the whole frame, inverted when `cfg_par_odd`=1.
- R7: After a final segment and its parity bit, if any, `sclk` stays low for `cfg_idle` bit periods (0 to 15). The next frame's first rising edge therefore comes 2*(`cfg_idle`+1) clocks after the previous rising edge, when the next word is ready.
- R8: A final word with `cfg_len` from 1 to 6 is an error unless it directly follows a chained segment. Such a word is taken from the slot and dropped, no bit is sent for it, and `len_err` pulses for one clock. A length of 7 is accepted on its own.
- R9: If a chained segment ends while the slot is empty, `sclk` stays low and `underrun` pulses for one clock. The frame resumes with the next word, and no parity or idle gap is inserted at the pause. Parity still covers the whole frame.
- R10: Each bit lasts two clocks: `sclk` is low in the first and high in the second. `sdo` is stable across both clocks. When idle, `sclk` is low and `sdo` is 0.
- R11: After reset, `sclk`=0, `sdo`=0, `s_ready`=1, and `underrun` and `len_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Transmit word valid |
| s_ready | output | 1 | Holding slot empty, word will be taken |
| s_data | input | 32 | Transmit word: bit 29 is the chain flag, bits 15:0 are the payload |
| cfg_len | input | 4 | Length of a final segment, 0 means 16 |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: highest active bit first |
| cfg_par_en | input | 1 | Append a frame parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_idle | input | 4 | Idle bit periods after a frame |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, valid while sclk rises |
| underrun | output | 1 | One-clock pulse: a chain stalled for lack of a word |
| len_err | output | 1 | One-clock pulse: a short final word was dropped |

## Verification
The bench sweeps every final length from 1 to 16 in both bit orders and all three parity settings, each behind a chained segment, and rebuilds the expected serial stream bit by bit. These runs would expose:
- a block that kept the configured length for chained words;
- a block that took its bits from the wrong end of the payload;
- a block that placed parity after each segment;
- a block that opened a gap at a chain boundary.

A second sweep measures the spacing between frames for every idle setting from 0 to 15, which catches off-by-one errors in the gap counter. Directed cases cover the short-length rule at 3, 6 and 7 bits, and a chain starved of its next word. In the starved case a wrong design would either put out an idle gap or parity early, or lose the pause without flagging it.

// File: rtl/chain_ser_pkg.sv
package chain_ser_pkg;
  localparam int WORD_W_DEF    = 32;
  localparam int SEG_W_DEF     = 16;
  localparam int LEN_W_DEF     = 4;
  localparam int IDLE_W_DEF    = 4;
  localparam int CHAIN_BIT_DEF = 29;
  localparam int MIN_LEN_DEF   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_PAR,
    ST_GAP,
    ST_STALL
  } ser_state_e;
endpackage

// File: rtl/chain_ser_hold.sv
module chain_ser_hold #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] data
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/chain_ser_parity.sv
module chain_ser_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  input  logic odd,
  output logic par_out
);
  logic acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= 1'b0;
    else if (clr) acc <= 1'b0;
    else if (en)  acc <= acc ^ bit_in;
  end

  assign par_out = acc ^ odd;
endmodule

// File: rtl/chain_ser_engine.sv
module chain_ser_engine
  import chain_ser_pkg::*;
#(
  parameter int SEG_W   = SEG_W_DEF,
  parameter int LEN_W   = LEN_W_DEF,
  parameter int IDLE_W  = IDLE_W_DEF,
  parameter int MIN_LEN = MIN_LEN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_full,
  input  logic [SEG_W-1:0]  hold_pay,
  input  logic              hold_chain,
  output logic              pop,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_lsb_first,
  input  logic              cfg_par_en,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              par_bit,
  output logic              acc_clr,
  output logic              acc_en,
  output logic              acc_bit,
  output logic              sclk,
  output logic              sdo,
  output logic              underrun,
  output logic              len_err
);
  localparam int CNT_W = $clog2(SEG_W + 1);
  localparam int GCW   = (CNT_W > IDLE_W) ? CNT_W : IDLE_W;

  ser_state_e       st;
  logic [SEG_W-1:0] shreg;
  logic [GCW-1:0]   nlen, cnt, cfg_n, w_n, lsb_pos, pos;
  logic             phase, chn;
  logic             w_bad, ld_req, start, drop, data_bit, cnt_zero, idle_zero;

  assign cnt_zero  = (cnt == '0);
  assign idle_zero = (cfg_idle == '0);
  assign cfg_n     = (cfg_len == '0) ? GCW'(SEG_W) : GCW'(cfg_len);
  assign w_n       = hold_chain ? GCW'(SEG_W) : cfg_n;
  assign w_bad     = !hold_chain && (cfg_len != '0) && (cfg_n < GCW'(MIN_LEN)) && !chn;

  always_comb begin
    case (st)
      ST_IDLE, ST_STALL: ld_req = 1'b1;
      ST_SHIFT: ld_req = phase && cnt_zero && (chn || (!cfg_par_en && idle_zero));
      ST_PAR:   ld_req = phase && idle_zero;
      ST_GAP:   ld_req = phase && cnt_zero;
      default:  ld_req = 1'b0;
    endcase
  end

  assign pop   = ld_req && hold_full;
  assign start = pop && !w_bad;
  assign drop  = pop && w_bad;

  assign lsb_pos  = nlen - cnt - GCW'(1);
  assign pos      = cfg_lsb_first ? lsb_pos : cnt;
  assign data_bit = |(shreg & (SEG_W'(1) << pos));

  assign sclk    = ((st == ST_SHIFT) || (st == ST_PAR)) && phase;
  assign sdo     = (st == ST_SHIFT) ? data_bit : ((st == ST_PAR) ? par_bit : 1'b0);
  assign acc_clr = start && !chn;
  assign acc_en  = (st == ST_SHIFT) && phase;
  assign acc_bit = data_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      nlen     <= '0;
      cnt      <= '0;
      phase    <= 1'b0;
      chn      <= 1'b0;
      underrun <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      underrun <= ld_req && !hold_full && chn && (st == ST_SHIFT);
      len_err  <= drop;
      if (start) begin
        shreg <= hold_pay;
        nlen  <= w_n;
        cnt   <= w_n - GCW'(1);
        phase <= 1'b0;
        chn   <= hold_chain;
        st    <= ST_SHIFT;
      end else if (ld_req) begin
        phase <= 1'b0;
        st    <= (chn && ((st == ST_SHIFT) || (st == ST_STALL))) ? ST_STALL : ST_IDLE;
      end else begin
        case (st)
          ST_SHIFT: begin
            phase <= !phase;
            if (phase) begin
              if (!cnt_zero)       cnt <= cnt - GCW'(1);
              else if (cfg_par_en) st  <= ST_PAR;
              else begin
                st  <= ST_GAP;
                cnt <= GCW'(cfg_idle) - GCW'(1);
              end
            end
          end
          ST_PAR: begin
            phase <= !phase;
            if (phase) begin
              st  <= ST_GAP;
              cnt <= GCW'(cfg_idle) - GCW'(1);
            end
          end
          ST_GAP: begin
            phase <= !phase;
            if (phase) cnt <= cnt - GCW'(1);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chain_ser_tx.sv
module chain_ser_tx
  import chain_ser_pkg::*;
#(
  parameter int WORD_W    = WORD_W_DEF,
  parameter int SEG_W     = SEG_W_DEF,
  parameter int LEN_W     = LEN_W_DEF,
  parameter int IDLE_W    = IDLE_W_DEF,
  parameter int CHAIN_BIT = CHAIN_BIT_DEF,
  parameter int MIN_LEN   = MIN_LEN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_lsb_first,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [IDLE_W-1:0] cfg_idle,
  output logic              sclk,
  output logic              sdo,
  output logic              underrun,
  output logic              len_err
);
  localparam int HW = SEG_W + 1;

  logic [HW-1:0] hold_data;
  logic          hold_full, pop, par_bit, acc_clr, acc_en, acc_bit;

  chain_ser_hold #(.W(HW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_valid),
    .in_ready (s_ready),
    .in_data  ({s_data[CHAIN_BIT], s_data[SEG_W-1:0]}),
    .pop      (pop),
    .full     (hold_full),
    .data     (hold_data)
  );

  chain_ser_parity u_par (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .en      (acc_en),
    .bit_in  (acc_bit),
    .odd     (cfg_par_odd),
    .par_out (par_bit)
  );

  chain_ser_engine #(
    .SEG_W   (SEG_W),
    .LEN_W   (LEN_W),
    .IDLE_W  (IDLE_W),
    .MIN_LEN (MIN_LEN)
  ) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold_full     (hold_full),
    .hold_pay      (hold_data[SEG_W-1:0]),
    .hold_chain    (hold_data[SEG_W]),
    .pop           (pop),
    .cfg_len       (cfg_len),
    .cfg_lsb_first (cfg_lsb_first),
    .cfg_par_en    (cfg_par_en),
    .cfg_idle      (cfg_idle),
    .par_bit       (par_bit),
    .acc_clr       (acc_clr),
    .acc_en        (acc_en),
    .acc_bit       (acc_bit),
    .sclk          (sclk),
    .sdo           (sdo),
    .underrun      (underrun),
    .len_err       (len_err)
  );
endmodule

// File: rtl/chain_ser_tx_chk.sv
module chain_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic sclk,
  input logic sdo,
  input logic underrun,
  input logic len_err
);
  assert_slot_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_high_one_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> !sclk);

  assert_data_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));

  assert_stall_clk_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !sclk);

  assert_drop_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (!sclk && !underrun));
endmodule

bind chain_ser_tx chain_ser_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .sclk     (sclk),
  .sdo      (sdo),
  .underrun (underrun),
  .len_err  (len_err)
);

// File: tb/chain_ser_tx_bench.sv
module chain_ser_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid;
  logic        s_ready;
  logic [31:0] s_data;
  logic [3:0]  cfg_len;
  logic        cfg_lsb_first, cfg_par_en, cfg_par_odd;
  logic [3:0]  cfg_idle;
  logic        sclk, sdo, underrun, len_err;

  always #4 clk = ~clk;

  chain_ser_tx u_chain_ser_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_idle(cfg_idle), .sclk(sclk), .sdo(sdo),
    .underrun(underrun), .len_err(len_err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_urun = 0, n_lerr = 0;
  bit sclk_d = 1'b0;
  bit rq[$];
  int tq[$];
  bit eq[$];
  bit epar;

  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclk_d) begin
      rq.push_back(sdo);
      tq.push_back(cyc);
    end
    sclk_d = sclk;
    if (underrun) n_urun++;
    if (len_err) n_lerr++;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    check(s_ready == 1'b0, "R1", "slot closes after accept", int'(s_ready), 0);
  endtask

  task automatic clear_mon();
    rq.delete(); tq.delete(); eq.delete(); epar = 1'b0;
  endtask

  task automatic add_seg(logic [15:0] p, int n, bit lsb);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = p[lsb ? i : n - 1 - i];
      eq.push_back(b);
      epar ^= b;
    end
  endtask

  task automatic cmp_stream(string req, string what);
    int bad_at;
    bad_at = -1;
    if (rq.size() == eq.size()) begin
      for (int i = 0; i < eq.size(); i++)
        if (rq[i] != eq[i] && bad_at < 0) bad_at = i;
    end
    check(rq.size() == eq.size(), req, {what, " bit count"}, rq.size(), eq.size());
    if (rq.size() == eq.size())
      check(bad_at < 0, req, {what, " first wrong bit index"}, bad_at, -1);
  endtask

  task automatic wait_quiet();
    repeat (120) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int lerr0, urun0, gap_bad;
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0;
    cfg_len = 4'd8; cfg_lsb_first = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_idle = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk == 0 && sdo == 0, "R11", "serial pins after reset", {sclk, sdo}, 0);
    check(s_ready == 1'b1, "R11", "ready after reset", int'(s_ready), 1);
    check(underrun == 0 && len_err == 0, "R11", "flags after reset", {underrun, len_err}, 0);

    // R2 R3 R4 R5 R6: chained segment plus final segment, every length, order, parity mode
    for (int lsb = 0; lsb < 2; lsb++)
      for (int len = 1; len <= 16; len++)
        for (int pm = 0; pm < 3; pm++) begin
          logic [15:0] pa, pb;
          pa = 16'hA0C5 ^ 16'(len * 16'h1357) ^ 16'(pm * 16'h0F0F) ^ 16'(lsb * 16'h8001);
          pb = 16'h5A3C ^ 16'(len * 16'h2468) ^ 16'(pm * 16'h3003);
          cfg_len = 4'(len); cfg_lsb_first = 1'(lsb);
          cfg_par_en = (pm != 0); cfg_par_odd = (pm == 2); cfg_idle = 4'd2;
          clear_mon();
          add_seg(pa, 16, 1'(lsb));
          add_seg(pb, len, 1'(lsb));
          if (pm != 0) eq.push_back(epar ^ (pm == 2));
          lerr0 = n_lerr; urun0 = n_urun;
          push(32'h6001_0000 | 32'(pa));
          push(32'h8002_0000 | 32'(pb));
          wait_quiet();
          cmp_stream("R2/R3/R5/R6", $sformatf("chain lsb=%0d len=%0d par=%0d", lsb, len, pm));
          gap_bad = 0;
          for (int i = 1; i < tq.size(); i++) if (tq[i] - tq[i-1] != 2) gap_bad++;
          check(gap_bad == 0, "R4", "bit spacing inside chained frame", gap_bad, 0);
          check(n_lerr == lerr0 && n_urun == urun0, "R8", "no flag on valid chain",
                n_lerr - lerr0 + n_urun - urun0, 0);
        end

    // R7: idle gap length sweep
    cfg_len = 4'd8; cfg_lsb_first = 1'b0; cfg_par_en = 1'b0;
    for (int idl = 0; idl < 16; idl++) begin
      cfg_idle = 4'(idl);
      clear_mon();
      add_seg(16'h77A5, 8, 1'b0);
      add_seg(16'h123C, 8, 1'b0);
      push(32'h0000_77A5);
      push(32'h0000_123C);
      wait_quiet();
      cmp_stream("R7", $sformatf("two frames idle=%0d", idl));
      if (tq.size() == 16)
        check(tq[8] - tq[7] == 2 * (idl + 1), "R7", "edge spacing across idle gap",
              tq[8] - tq[7], 2 * (idl + 1));
    end

    // R8: short standalone final words
    cfg_idle = 4'd1;
    cfg_len = 4'd3; clear_mon(); lerr0 = n_lerr;
    push(32'h0000_0005);
    wait_quiet();
    check(n_lerr == lerr0 + 1, "R8", "len 3 standalone flagged", n_lerr - lerr0, 1);
    check(rq.size() == 0, "R8", "len 3 standalone sends nothing", rq.size(), 0);
    cfg_len = 4'd6; clear_mon(); lerr0 = n_lerr;
    push(32'h0000_002D);
    wait_quiet();
    check(n_lerr == lerr0 + 1, "R8", "len 6 standalone flagged", n_lerr - lerr0, 1);
    check(rq.size() == 0, "R8", "len 6 standalone sends nothing", rq.size(), 0);
    cfg_len = 4'd7; clear_mon(); lerr0 = n_lerr;
    add_seg(16'h005B, 7, 1'b0);
    push(32'h0000_005B);
    wait_quiet();
    check(n_lerr == lerr0, "R8", "len 7 standalone accepted", n_lerr - lerr0, 0);
    cmp_stream("R8", "len 7 standalone");

    // R9: starved chain with parity
    cfg_len = 4'd5; cfg_lsb_first = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    clear_mon(); urun0 = n_urun;
    add_seg(16'hC3E1, 16, 1'b1);
    add_seg(16'h0016, 5, 1'b1);
    eq.push_back(epar);
    push(32'h2000_C3E1);
    repeat (70) @(negedge clk);
    push(32'h0000_0016);
    wait_quiet();
    check(n_urun == urun0 + 1, "R9", "underrun pulses once", n_urun - urun0, 1);
    cmp_stream("R9", "stalled chain stream with parity");
    if (tq.size() == 22)
      check(tq[16] - tq[15] > 2, "R9", "clock paused at stall", tq[16] - tq[15], 3);

    summary();
  end
endmodule